// File: doc/BRIEF.md
# Relocatable SRAM Bank Controller

This block holds four small on-chip SRAM banks that the processor alone reaches. Every bank answers inside one 512-byte window whose base address software chooses. On each processor bus access the incoming address is compared with all enabled windows. On a hit, the matching bank serves the access and the block raises a signal that suppresses the external bus cycle, even where external chip-select logic also decodes that address.

Software programs each bank through a small set of configuration registers. These hold a base address per bank, plus one control word with a per-bank enable bit and a per-bank write-protect bit. The configuration registers answer supervisor accesses only. A user-mode access gets a bus-error response and changes nothing. A write into a protected bank is still claimed by the block. The memory keeps its contents, and a status pulse reports the blocked write.

Top module: `sram_bank_ctrl`

## Requirements
- R1: After reset every base register and the control register read 0, and no bus access raises `ext_suppress_o`.
- R2: A bus access hits bank n when bank n is enabled and `bus_addr_i[31:9]` equals its base bits [31:9]; address bits [8:0] take no part in the compare. `ext_suppress_o` is high in the same cycle as a request that hits and low otherwise.
- R3: A bank whose enable bit is 0 never produces a hit.
- R4: A read hit returns the addressed word on `bus_rdata_o` with `bus_rvalid_o` high one clock after the request. `bus_rvalid_o` is low after writes, misses and idle cycles.
- R5: On a write hit, `bus_be_i[k]` set writes byte lane bits [8k+7:8k]; lanes whose enable is clear keep their old value.
- R6: When the write-protect bit of the hit bank is set, a write leaves the bank unchanged, still raises `ext_suppress_o`, and pulses `wp_err_o` for one cycle, one clock after the request. Unprotected writes leave `wp_err_o` low.
- R7: A configuration access with `cfg_super_i` low answers with `cfg_berr_o` high and `cfg_ack_o` low one clock later, and leaves every register unchanged.
- R8: Register map on `cfg_addr_i`: values 0 to 3 select the base of bank 0 to 3, kept in bits [31:9], with bits [8:0] reading 0. Value 4 selects the control word, with the enables in [3:0], the write-protects in [11:8] and all other bits reading 0. Values 5 to 7 read 0 and ignore writes. A supervisor access answers with `cfg_ack_o` and, for reads, the register value on `cfg_rdata_o` one clock later.
- R9: When several enabled windows match one address, the lowest-numbered bank serves the access.
- R10: Each bank stores 128 words of 32 bits, indexed by `bus_addr_i[8:2]`; writing one bank never alters another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Processor bus access request |
| bus_we_i | input | 1 | Access is a write |
| bus_addr_i | input | 32 | Byte address of the access |
| bus_be_i | input | 4 | Byte-lane write enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one clock after a read hit |
| ext_suppress_o | output | 1 | Access hit a bank; external cycle must not run |
| wp_err_o | output | 1 | One-cycle pulse for a write blocked by write protect |
| cfg_req_i | input | 1 | Configuration register access request |
| cfg_we_i | input | 1 | Configuration access is a write |
| cfg_super_i | input | 1 | Configuration access is in supervisor mode |
| cfg_addr_i | input | 3 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| cfg_ack_o | output | 1 | Configuration access accepted |
| cfg_berr_o | output | 1 | Configuration access refused (bus error) |

## Verification
The assertions assume single-cycle request pulses with no back-pressure. Every request counts as a complete access in the cycle it is high, and every data or response output refers to the request one clock earlier. They also assume that the processor is the only master driving the bus inputs. Bus and configuration requests may arrive in any mix, and the checks relate each response only to the request of the previous cycle. The stimulus follows this by holding each request high for exactly one clock and then dropping it while the response is sampled. Inputs are driven at the falling edge. Overlapping windows are used only in the test that targets the lowest-bank priority.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // control word layout
  localparam int unsigned CTRL_EN_LSB = 0;
  localparam int unsigned CTRL_WP_LSB = 8;
endpackage

// File: rtl/sbc_cfg_regs.sv
module sbc_cfg_regs
  import sbc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OFFS_W    = 9,
  parameter int unsigned CFG_AW    = 3,
  localparam int unsigned TAG_W    = DATA_W - OFFS_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_req_i,
  input  logic                             cfg_we_i,
  input  logic                             cfg_super_i,
  input  logic [CFG_AW-1:0]                cfg_addr_i,
  input  logic [DATA_W-1:0]                cfg_wdata_i,
  output logic [DATA_W-1:0]                cfg_rdata_o,
  output logic                             cfg_ack_o,
  output logic                             cfg_berr_o,
  output logic [NUM_BANKS-1:0][TAG_W-1:0]  base_o,
  output logic [NUM_BANKS-1:0]             en_o,
  output logic [NUM_BANKS-1:0]             wp_o
);
  logic [NUM_BANKS-1:0][TAG_W-1:0] base_q;
  logic [NUM_BANKS-1:0]            en_q, wp_q;
  logic [DATA_W-1:0]               rd_val, rdata_q;
  logic                            ack_q, berr_q;
  logic                            wr_ok;

  assign wr_ok = cfg_req_i && cfg_super_i && cfg_we_i;

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (cfg_addr_i == CFG_AW'(b)) rd_val = {base_q[b], {OFFS_W{1'b0}}};
    if (cfg_addr_i == CFG_AW'(NUM_BANKS)) begin
      rd_val[CTRL_EN_LSB +: NUM_BANKS] = en_q;
      rd_val[CTRL_WP_LSB +: NUM_BANKS] = wp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      en_q    <= '0;
      wp_q    <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      ack_q   <= cfg_req_i && cfg_super_i;
      berr_q  <= cfg_req_i && !cfg_super_i;
      rdata_q <= (cfg_req_i && cfg_super_i) ? rd_val : '0;
      if (wr_ok) begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (cfg_addr_i == CFG_AW'(b)) base_q[b] <= cfg_wdata_i[DATA_W-1:OFFS_W];
        if (cfg_addr_i == CFG_AW'(NUM_BANKS)) begin
          en_q <= cfg_wdata_i[CTRL_EN_LSB +: NUM_BANKS];
          wp_q <= cfg_wdata_i[CTRL_WP_LSB +: NUM_BANKS];
        end
      end
    end
  end

  assign cfg_rdata_o = rdata_q;
  assign cfg_ack_o   = ack_q;
  assign cfg_berr_o  = berr_q;
  assign base_o      = base_q;
  assign en_o        = en_q;
  assign wp_o        = wp_q;
endmodule

// File: rtl/sbc_addr_match.sv
module sbc_addr_match #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned TAG_W     = 23,
  localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [TAG_W-1:0]                tag_i,
  input  logic [NUM_BANKS-1:0][TAG_W-1:0] base_i,
  input  logic [NUM_BANKS-1:0]            en_i,
  output logic                            hit_o,
  output logic [SEL_W-1:0]                sel_o
);
  logic [NUM_BANKS-1:0] match;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign match[b] = en_i[b] && (tag_i == base_i[b]);
  end

  // lowest index wins on overlap
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--)
      if (match[b]) begin
        hit_o = 1'b1;
        sel_o = SEL_W'(b);
      end
  end
endmodule

// File: rtl/sbc_bank_mem.sv
module sbc_bank_mem #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned NBYTE = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [NBYTE-1:0]  be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i)
      for (int k = 0; k < NBYTE; k++)
        if (be_i[k]) mem_q[idx_i][8*k +: 8] <= wdata_i[8*k +: 8];
    if (re_i) rdata_q <= mem_q[idx_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_BYTES = 512,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CFG_AW     = $clog2(NUM_BANKS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic [DATA_W-1:0]   bus_addr_i,
  input  logic [DATA_W/8-1:0] bus_be_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                bus_rvalid_o,
  output logic                ext_suppress_o,
  output logic                wp_err_o,
  input  logic                cfg_req_i,
  input  logic                cfg_we_i,
  input  logic                cfg_super_i,
  input  logic [CFG_AW-1:0]   cfg_addr_i,
  input  logic [DATA_W-1:0]   cfg_wdata_i,
  output logic [DATA_W-1:0]   cfg_rdata_o,
  output logic                cfg_ack_o,
  output logic                cfg_berr_o
);
  localparam int unsigned OFFS_W = $clog2(BANK_BYTES);
  localparam int unsigned LANE_W = $clog2(DATA_W / 8);
  localparam int unsigned WORDS  = BANK_BYTES / (DATA_W / 8);
  localparam int unsigned IDX_W  = OFFS_W - LANE_W;
  localparam int unsigned TAG_W  = DATA_W - OFFS_W;
  localparam int unsigned SEL_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [NUM_BANKS-1:0][TAG_W-1:0]  base;
  logic [NUM_BANKS-1:0]             en, wp;
  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rdata;
  logic                             hit, acc;
  logic [SEL_W-1:0]                 sel, rd_sel_q;
  logic                             rvalid_q, wp_err_q;
  logic [IDX_W-1:0]                 widx;
  logic [LANE_W-1:0]                unused_lane;

  assign widx        = bus_addr_i[OFFS_W-1:LANE_W];
  assign unused_lane = bus_addr_i[LANE_W-1:0];

  sbc_cfg_regs #(
    .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .CFG_AW(CFG_AW)
  ) u_cfg (
    .clk_i, .rst_ni, .cfg_req_i, .cfg_we_i, .cfg_super_i, .cfg_addr_i,
    .cfg_wdata_i, .cfg_rdata_o, .cfg_ack_o, .cfg_berr_o,
    .base_o(base), .en_o(en), .wp_o(wp)
  );

  sbc_addr_match #(.NUM_BANKS(NUM_BANKS), .TAG_W(TAG_W)) u_match (
    .tag_i(bus_addr_i[DATA_W-1:OFFS_W]), .base_i(base), .en_i(en),
    .hit_o(hit), .sel_o(sel)
  );

  assign acc            = bus_req_i && hit;
  assign ext_suppress_o = acc;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_b;
    assign sel_b = acc && (sel == SEL_W'(b));
    sbc_bank_mem #(.WORDS(WORDS), .DATA_W(DATA_W)) u_mem (
      .clk_i,
      .we_i   (sel_b && bus_we_i && !wp[b]),
      .re_i   (sel_b && !bus_we_i),
      .be_i   (bus_be_i),
      .idx_i  (widx),
      .wdata_i(bus_wdata_i),
      .rdata_o(bank_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      wp_err_q <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      rvalid_q <= acc && !bus_we_i;
      wp_err_q <= acc && bus_we_i && wp[sel];
      if (acc && !bus_we_i) rd_sel_q <= sel;
    end
  end

  assign bus_rdata_o  = rvalid_q ? bank_rdata[rd_sel_q] : '0;
  assign bus_rvalid_o = rvalid_q;
  assign wp_err_o     = wp_err_q;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_req_i,
  input logic bus_we_i,
  input logic bus_rvalid_o,
  input logic ext_suppress_o,
  input logic wp_err_o,
  input logic cfg_req_i,
  input logic cfg_super_i,
  input logic cfg_ack_o,
  input logic cfg_berr_o
);
  a_r2_suppress_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_suppress_o |-> bus_req_i);

  a_r4_read_hit_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && ext_suppress_o) |=> bus_rvalid_o);

  a_r4_valid_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o |-> $past(bus_req_i && !bus_we_i && ext_suppress_o));

  a_r6_wp_after_write_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_err_o |-> $past(bus_req_i && bus_we_i && ext_suppress_o));

  a_r7_user_gets_berr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && !cfg_super_i) |=> (cfg_berr_o && !cfg_ack_o));

  a_r8_super_gets_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && cfg_super_i) |=> (cfg_ack_o && !cfg_berr_o));

  a_r8_response_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ack_o || cfg_berr_o) |-> $past(cfg_req_i));
endmodule

bind sram_bank_ctrl sbc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_rvalid_o(bus_rvalid_o), .ext_suppress_o(ext_suppress_o),
  .wp_err_o(wp_err_o), .cfg_req_i(cfg_req_i), .cfg_super_i(cfg_super_i),
  .cfg_ack_o(cfg_ack_o), .cfg_berr_o(cfg_berr_o)
);

// File: tb/sram_bank_ctrl_tb_top.sv
module sram_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 0, bus_we = 0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, ext_sup, wp_err;
  logic        cfg_req = 0, cfg_we = 0, cfg_super = 0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        cfg_ack, cfg_berr;
  int          n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  sram_bank_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .ext_suppress_o(ext_sup), .wp_err_o(wp_err),
    .cfg_req_i(cfg_req), .cfg_we_i(cfg_we), .cfg_super_i(cfg_super),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .cfg_ack_o(cfg_ack), .cfg_berr_o(cfg_berr)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        hit;
    logic [31:0] rdata;
  } vec_t;

  // bases: bank0 0x10000, bank1 0x10200, bank2 0x20000, bank3 0x30000 (disabled)
  localparam vec_t VECS [16] = '{
    '{1'b1, 32'h0001_0000, 4'hF, 32'h1122_3344, 1'b1, 32'h0},
    '{1'b0, 32'h0001_0000, 4'h0, 32'h0,         1'b1, 32'h1122_3344},
    '{1'b1, 32'h0001_01FC, 4'hF, 32'hCAFE_F00D, 1'b1, 32'h0},
    '{1'b0, 32'h0001_01FC, 4'h0, 32'h0,         1'b1, 32'hCAFE_F00D},
    '{1'b1, 32'h0001_0204, 4'hF, 32'hAABB_CCDD, 1'b1, 32'h0},
    '{1'b0, 32'h0001_0204, 4'h0, 32'h0,         1'b1, 32'hAABB_CCDD},
    '{1'b1, 32'h0001_0204, 4'h1, 32'h0000_00EE, 1'b1, 32'h0},
    '{1'b0, 32'h0001_0204, 4'h0, 32'h0,         1'b1, 32'hAABB_CCEE},
    '{1'b1, 32'h0001_0204, 4'hC, 32'h1234_0000, 1'b1, 32'h0},
    '{1'b0, 32'h0001_0204, 4'h0, 32'h0,         1'b1, 32'h1234_CCEE},
    '{1'b1, 32'h0002_0008, 4'hF, 32'h0000_0055, 1'b1, 32'h0},
    '{1'b0, 32'h0002_0008, 4'h0, 32'h0,         1'b1, 32'h0000_0055},
    '{1'b0, 32'h0001_0000, 4'h0, 32'h0,         1'b1, 32'h1122_3344},
    '{1'b0, 32'h0003_0000, 4'h0, 32'h0,         1'b0, 32'h0},
    '{1'b0, 32'h0001_0400, 4'h0, 32'h0,         1'b0, 32'h0},
    '{1'b1, 32'h0001_0600, 4'hF, 32'hFFFF_FFFF, 1'b0, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input logic exp_hit, input logic exp_wp,
                        input logic [31:0] exp_rd, input string tag);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = addr; bus_be = be; bus_wdata = wd;
    #1 chk({tag, " suppress"}, 32'(ext_sup), 32'(exp_hit));
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    chk({tag, " rvalid"}, 32'(bus_rvalid), 32'(exp_hit && !we));
    chk({tag, " wp_err"}, 32'(wp_err), 32'(exp_wp));
    if (exp_hit && !we) chk({tag, " rdata"}, bus_rdata, exp_rd);
  endtask

  task automatic cfg_op(input logic we, input logic sup, input logic [2:0] addr,
                        input logic [31:0] wd, input logic chk_rd,
                        input logic [31:0] exp_rd, input string tag);
    @(negedge clk);
    cfg_req = 1; cfg_we = we; cfg_super = sup; cfg_addr = addr; cfg_wdata = wd;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
    chk({tag, " ack"},  32'(cfg_ack),  32'(sup));
    chk({tag, " berr"}, 32'(cfg_berr), 32'(!sup));
    if (chk_rd) chk({tag, " rdata"}, cfg_rdata, exp_rd);
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int r = 0; r < 5; r++) cfg_op(0, 1, 3'(r), 0, 1, 32'h0, "R1 reg after reset");
    bus_op(0, 32'h0000_0000, 4'h0, 0, 0, 0, 0, "R1 no hit after reset");

    // R8: setup and map
    cfg_op(1, 1, 3'd0, 32'h0001_01FF, 0, 0, "R8 wr base0");
    cfg_op(0, 1, 3'd0, 0, 1, 32'h0001_0000, "R8 base low bits read 0");
    cfg_op(1, 1, 3'd1, 32'h0001_0200, 0, 0, "R8 wr base1");
    cfg_op(1, 1, 3'd2, 32'h0002_0000, 0, 0, "R8 wr base2");
    cfg_op(1, 1, 3'd3, 32'h0003_0000, 0, 0, "R8 wr base3");
    cfg_op(1, 1, 3'd4, 32'hFFFF_F0F7, 0, 0, "R8 wr ctrl");
    cfg_op(0, 1, 3'd4, 0, 1, 32'h0000_0007, "R8 ctrl fields");
    cfg_op(1, 1, 3'd5, 32'hFFFF_FFFF, 0, 0, "R8 wr unused");
    cfg_op(0, 1, 3'd5, 0, 1, 32'h0, "R8 unused reads 0");

    // R2 R3 R4 R5 R10: vector walk
    foreach (VECS[i])
      bus_op(VECS[i].we, VECS[i].addr, VECS[i].be, VECS[i].wdata, VECS[i].hit, 1'b0,
             VECS[i].rdata, $sformatf("R2/R3/R4/R5/R10 vec%0d", i));

    // R7: user access refused, no change
    cfg_op(1, 0, 3'd4, 32'h0000_0F0F, 0, 0, "R7 user wr ctrl");
    cfg_op(1, 0, 3'd1, 32'h0009_0000, 0, 0, "R7 user wr base1");
    cfg_op(0, 0, 3'd4, 0, 1, 32'h0, "R7 user rd ctrl");
    cfg_op(0, 1, 3'd4, 0, 1, 32'h0000_0007, "R7 ctrl unchanged");
    cfg_op(0, 1, 3'd1, 0, 1, 32'h0001_0200, "R7 base1 unchanged");

    // R6: write protect bank1
    cfg_op(1, 1, 3'd4, 32'h0000_0207, 0, 0, "R6 set wp1");
    bus_op(1, 32'h0001_0204, 4'hF, 32'h0, 1, 1, 0, "R6 protected write");
    bus_op(0, 32'h0001_0204, 4'h0, 0, 1, 0, 32'h1234_CCEE, "R6 content kept");
    bus_op(1, 32'h0001_0004, 4'hF, 32'h0000_0066, 1, 0, 0, "R6 other bank writable");
    bus_op(0, 32'h0001_0004, 4'h0, 0, 1, 0, 32'h0000_0066, "R6 other bank read");

    // R9: overlap, lowest bank wins
    cfg_op(1, 1, 3'd4, 32'h0000_000F, 0, 0, "R9 enable all");
    bus_op(1, 32'h0003_0000, 4'hF, 32'hB3B3_B3B3, 1, 0, 0, "R3 bank3 now hits");
    cfg_op(1, 1, 3'd3, 32'h0001_0000, 0, 0, "R9 move bank3 onto bank0");
    bus_op(0, 32'h0001_0000, 4'h0, 0, 1, 0, 32'h1122_3344, "R9 bank0 wins");
    cfg_op(1, 1, 3'd4, 32'h0000_000E, 0, 0, "R9 disable bank0");
    bus_op(0, 32'h0001_0000, 4'h0, 0, 1, 0, 32'hB3B3_B3B3, "R2 relocated bank3");
    cfg_op(1, 1, 3'd4, 32'h0000_0000, 0, 0, "R3 disable all");
    bus_op(0, 32'h0001_0000, 4'h0, 0, 0, 0, 0, "R3 no hit when disabled");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule